// File: doc/BRIEF.md
# Root Hub Port Status Register

This block holds the status and control word of one downstream port of a full/low-speed USB host controller's root hub. Software reads a single 32-bit word that reports whether a device is attached, whether the port is enabled, suspended, in reset or powered, whether the attached device is low-speed, and two sticky change flags. Writes to the same word are not stores. Each set bit in the written word is a command, such as "enable the port", "suspend", "start reset", "power on", "power off" or "clear this change flag". The meaning of a bit on write can differ from its meaning on read.

Hardware events come in as single-cycle pulses: attach, detach, reset completion, a hardware-caused disable and overcurrent. Global power-on and power-off commands also arrive as pulses. A switching-mode level and a per-port mask bit decide whether this port takes its power commands from the global pulses or from its own register writes. Two parameters fix whether power switching exists at all, and whether the attached device is non-removable, in which case connect changes are reported only once after reset.

Top module: `usb_rh_port_reg`

## Requirements
- R1: The read word places connect status at bit 0, enable status at bit 1, suspend status at bit 2, reset status at bit 4, power status at bit 8, low-speed indication at bit 9, connect change at bit 16 and enable change at bit 17. Every other bit reads 0.
- R2: The enable change flag (bit 17) is set when enable status is 1 and a hardware disable or a detach clears it. A driver write of 1 to bit 0 (clear enable) clears enable status without setting the flag.
- R3: Writing 1 to bit 16 or bit 17 clears that change flag, and writing 0 leaves it unchanged. A hardware set of the same flag in the same cycle wins over the clear.
- R4: With power on and the device not marked non-removable, every attach and every detach sets the connect change flag. Attach sets connect status and detach clears it.
- R5: While connect status is 0, a write of 1 to bit 4 (set reset), bit 1 (set enable) or bit 2 (set suspend) sets the connect change flag and does not change the reset, enable or suspend status.
- R6: Bit 9 reads the speed input latched at the last attach (1 = low-speed, 0 = full-speed). It reads 0 whenever connect status is 0.
- R7: An overcurrent pulse clears power status at the next clock edge.
- R8: With switching mode 0 (global), only the global power-on and power-off pulses change power status. Writes of 1 to bit 8 (power on) or bit 9 (power off) are ignored.
- R9: With switching mode 1 and the mask bit 1, only writes to bit 8 and bit 9 change power status, and the global pulses are ignored. With mode 1 and mask 0, only the global pulses change it.
- R10: In the edge at which power status becomes 0, connect, enable, suspend and reset status all become 0. While power is off, attach and detach events are ignored.
- R11: When built without power switching, power status reads 1 from reset onward, and power commands and overcurrent have no effect on it.
- R12: When built for a non-removable device, the connect change flag is set in the first cycle after reset ends, and attach or detach events never set it.
- R13: Write and event effects appear after the next clock edge. While connected, bit 1 sets enable status, bit 2 sets suspend status, bit 3 clears suspend status and bit 4 sets reset status. A reset-done pulse clears reset status and sets enable status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Command word; each set bit is one command |
| rd_data | output | 32 | Current status word |
| ev_connect | input | 1 | Device attach pulse |
| ev_disconnect | input | 1 | Device detach pulse |
| dev_lowspeed | input | 1 | Speed of the device attaching (1 = low-speed) |
| ev_reset_done | input | 1 | Port reset sequence finished pulse |
| ev_hw_disable | input | 1 | Hardware-caused disable pulse |
| ev_overcurrent | input | 1 | Overcurrent detected pulse |
| gpwr_set | input | 1 | Global power-on command pulse |
| gpwr_clr | input | 1 | Global power-off command pulse |
| pwr_mode | input | 1 | Power switching mode (0 global, 1 per-port) |
| pwr_mask | input | 1 | Per-port power control mask bit for this port |

## Verification
The bench builds two copies side by side on the same stimulus. One uses the defaults, with power switching present and the device removable. The other has no power switching and a non-removable device. The first reaches the global, per-port and masked power authorities, the overcurrent cut-off and the clearing of link state at power-off. The second shows power held at 1 through power-off pulses and overcurrent, the single connect-change report after reset, and attach or detach events that leave the change flag alone.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int REG_W = 32;

    localparam int B_CCS  = 0;
    localparam int B_PES  = 1;
    localparam int B_PSS  = 2;
    localparam int B_SUSX = 3;
    localparam int B_PRS  = 4;
    localparam int B_PPS  = 8;
    localparam int B_LSDA = 9;
    localparam int B_CSC  = 16;
    localparam int B_PESC = 17;

    typedef enum logic [1:0] {
        PWR_FIXED  = 2'd0,
        PWR_GLOBAL = 2'd1,
        PWR_PORT   = 2'd2
    } pwr_src_e;

    typedef struct packed {
        logic clr_en;
        logic set_en;
        logic set_susp;
        logic clr_susp;
        logic set_rst;
        logic set_pwr;
        logic clr_pwr;
        logic clr_csc;
        logic clr_pesc;
    } port_cmd_t;

    typedef struct packed {
        logic ccs;
        logic pes;
        logic pss;
        logic prs;
        logic lsda;
    } link_state_t;

    typedef struct packed {
        logic pesc;
        logic csc;
    } chg_flags_t;

    function automatic logic [REG_W-1:0] pack_status(
        input link_state_t s,
        input chg_flags_t  c,
        input logic        pps
    );
        logic [REG_W-1:0] w;
        w         = '0;
        w[B_CCS]  = s.ccs;
        w[B_PES]  = s.pes;
        w[B_PSS]  = s.pss;
        w[B_PRS]  = s.prs;
        w[B_PPS]  = pps;
        w[B_LSDA] = s.lsda & s.ccs;
        w[B_CSC]  = c.csc;
        w[B_PESC] = c.pesc;
        return w;
    endfunction

endpackage

// File: rtl/rh_cmd_decode.sv
module rh_cmd_decode
    import rh_port_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output port_cmd_t        cmd
);

    logic unused_wr;
    assign unused_wr = ^{wr_data[REG_W-1:B_PESC+1], wr_data[B_CSC-1:B_LSDA+1],
                         wr_data[B_PPS-1:B_PRS+1]};

    always_comb begin
        cmd          = '0;
        cmd.clr_en   = wr_en & wr_data[B_CCS];
        cmd.set_en   = wr_en & wr_data[B_PES];
        cmd.set_susp = wr_en & wr_data[B_PSS];
        cmd.clr_susp = wr_en & wr_data[B_SUSX];
        cmd.set_rst  = wr_en & wr_data[B_PRS];
        cmd.set_pwr  = wr_en & wr_data[B_PPS];
        cmd.clr_pwr  = wr_en & wr_data[B_LSDA];
        cmd.clr_csc  = wr_en & wr_data[B_CSC];
        cmd.clr_pesc = wr_en & wr_data[B_PESC];
    end

endmodule

// File: rtl/rh_power_ctrl.sv
module rh_power_ctrl
    import rh_port_pkg::*;
#(
    parameter bit POWER_SWITCHING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic port_on,
    input  logic port_off,
    input  logic gpwr_set,
    input  logic gpwr_clr,
    input  logic pwr_mode,
    input  logic pwr_mask,
    input  logic ev_overcurrent,
    output logic pps_q,
    output logic pps_next
);

    generate
        if (POWER_SWITCHING) begin : g_switched
            pwr_src_e src;
            logic     turn_on;
            logic     turn_off;

            always_comb begin
                src = (pwr_mode && pwr_mask) ? PWR_PORT : PWR_GLOBAL;
                unique case (src)
                    PWR_PORT: begin
                        turn_on  = port_on;
                        turn_off = port_off;
                    end
                    PWR_GLOBAL: begin
                        turn_on  = gpwr_set;
                        turn_off = gpwr_clr;
                    end
                    default: begin
                        turn_on  = 1'b0;
                        turn_off = 1'b0;
                    end
                endcase

                if (ev_overcurrent || turn_off) pps_next = 1'b0;
                else if (turn_on)               pps_next = 1'b1;
                else                            pps_next = pps_q;
            end

            always_ff @(posedge clk) begin
                if (rst) pps_q <= 1'b0;
                else     pps_q <= pps_next;
            end
        end else begin : g_fixed
            logic unused_pwr;
            assign unused_pwr = ^{clk, rst, port_on, port_off, gpwr_set, gpwr_clr,
                                  pwr_mode, pwr_mask, ev_overcurrent};
            assign pps_q    = 1'b1;
            assign pps_next = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rh_link_state.sv
module rh_link_state
    import rh_port_pkg::*;
#(
    parameter bit DEV_REMOVABLE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  port_cmd_t   cmd,
    input  logic        pps_next,
    input  logic        ev_connect,
    input  logic        ev_disconnect,
    input  logic        dev_lowspeed,
    input  logic        ev_reset_done,
    input  logic        ev_hw_disable,
    output link_state_t st_q,
    output chg_flags_t  chg_q
);

    link_state_t st_d;
    chg_flags_t  chg_d;
    logic        boot_done;
    logic        boot_pulse;
    logic        conn;
    logic        disc;
    logic        hw_drop;
    logic        idle_cmd;
    logic        csc_set;

    logic unused_cmd;
    assign unused_cmd = cmd.set_pwr ^ cmd.clr_pwr;

    assign boot_pulse = DEV_REMOVABLE && !boot_done;
    assign conn       = ev_connect & pps_next;
    assign disc       = ev_disconnect & pps_next;
    assign hw_drop    = st_q.pes & (ev_hw_disable | disc);
    assign idle_cmd   = !st_q.ccs & (cmd.set_rst | cmd.set_en | cmd.set_susp);
    assign csc_set    = boot_pulse | idle_cmd | (!DEV_REMOVABLE & (conn | disc));

    always_comb begin
        st_d = st_q;
        if (conn) begin
            st_d.ccs  = 1'b1;
            st_d.lsda = dev_lowspeed;
        end
        if (disc) st_d.ccs = 1'b0;

        if (st_q.ccs) begin
            if (cmd.set_en)   st_d.pes = 1'b1;
            if (cmd.set_susp) st_d.pss = 1'b1;
            if (cmd.set_rst)  st_d.prs = 1'b1;
            if (st_q.prs && ev_reset_done) begin
                st_d.prs = 1'b0;
                st_d.pes = 1'b1;
            end
        end
        if (cmd.clr_susp) st_d.pss = 1'b0;
        if (cmd.clr_en)   st_d.pes = 1'b0;
        if (ev_hw_disable || disc) st_d.pes = 1'b0;
        if (disc) begin
            st_d.pss = 1'b0;
            st_d.prs = 1'b0;
        end
        if (!pps_next) st_d = '0;

        chg_d.csc  = csc_set | (chg_q.csc & !cmd.clr_csc);
        chg_d.pesc = hw_drop | (chg_q.pesc & !cmd.clr_pesc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            chg_q     <= '0;
            boot_done <= 1'b0;
        end else begin
            st_q      <= st_d;
            chg_q     <= chg_d;
            boot_done <= 1'b1;
        end
    end

endmodule

// File: rtl/usb_rh_port_reg.sv
module usb_rh_port_reg
    import rh_port_pkg::*;
#(
    parameter bit POWER_SWITCHING = 1'b1,
    parameter bit DEV_REMOVABLE   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_connect,
    input  logic             ev_disconnect,
    input  logic             dev_lowspeed,
    input  logic             ev_reset_done,
    input  logic             ev_hw_disable,
    input  logic             ev_overcurrent,
    input  logic             gpwr_set,
    input  logic             gpwr_clr,
    input  logic             pwr_mode,
    input  logic             pwr_mask
);

    port_cmd_t   cmd;
    link_state_t st;
    chg_flags_t  chg;
    logic        pps;
    logic        pps_next;

    rh_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    rh_power_ctrl #(.POWER_SWITCHING(POWER_SWITCHING)) u_pwr (
        .clk            (clk),
        .rst            (rst),
        .port_on        (cmd.set_pwr),
        .port_off       (cmd.clr_pwr),
        .gpwr_set       (gpwr_set),
        .gpwr_clr       (gpwr_clr),
        .pwr_mode       (pwr_mode),
        .pwr_mask       (pwr_mask),
        .ev_overcurrent (ev_overcurrent),
        .pps_q          (pps),
        .pps_next       (pps_next)
    );

    rh_link_state #(.DEV_REMOVABLE(DEV_REMOVABLE)) u_link (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .pps_next      (pps_next),
        .ev_connect    (ev_connect),
        .ev_disconnect (ev_disconnect),
        .dev_lowspeed  (dev_lowspeed),
        .ev_reset_done (ev_reset_done),
        .ev_hw_disable (ev_hw_disable),
        .st_q          (st),
        .chg_q         (chg)
    );

    assign rd_data = pack_status(st, chg, pps);

endmodule

// File: rtl/rh_port_checker.sv
module rh_port_checker #(
    parameter bit POWER_SWITCHING = 1'b1,
    parameter bit DEV_REMOVABLE   = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        ev_disconnect,
    input logic        ev_hw_disable,
    input logic        ev_overcurrent,
    input logic        gpwr_set,
    input logic        pwr_mode,
    input logic        pwr_mask
);

    localparam logic [31:0] RSV_MASK = 32'hFFFC_FCE8;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_data & RSV_MASK) == 32'h0);

    assert_pesc_hw_only_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[17]) |-> $past(ev_hw_disable || ev_disconnect));

    assert_pesc_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[17] && !ev_hw_disable && !ev_disconnect) |=> !rd_data[17]);

    assert_lsda_needs_ccs_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_data[0] |-> !rd_data[9]);

    assert_unpowered_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_data[8] |-> (rd_data[4:0] == 5'd0));

    generate
        if (POWER_SWITCHING) begin : g_sw
            assert_oc_cuts_power_R7: assert property (@(posedge clk) disable iff (rst)
                ev_overcurrent |=> !rd_data[8]);
            // R8 (global authority) and R9 (per-port authority)
            assert_pps_rise_source_R9: assert property (@(posedge clk) disable iff (rst)
                $rose(rd_data[8]) |->
                    $past((pwr_mode && pwr_mask) ? (wr_en && wr_data[8]) : gpwr_set));
        end else begin : g_fixed
            assert_pps_fixed_R11: assert property (@(posedge clk) disable iff (rst)
                rd_data[8]);
        end
        if (DEV_REMOVABLE) begin : g_nr
            assert_csc_only_boot_R12: assert property (@(posedge clk) disable iff (rst)
                $rose(rd_data[16]) |->
                    ($past(rst, 2) ||
                     $past(wr_en && (wr_data[1] || wr_data[2] || wr_data[4]) && !rd_data[0])));
        end
    endgenerate

endmodule

bind usb_rh_port_reg rh_port_checker #(
    .POWER_SWITCHING (POWER_SWITCHING),
    .DEV_REMOVABLE   (DEV_REMOVABLE)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .ev_disconnect  (ev_disconnect),
    .ev_hw_disable  (ev_hw_disable),
    .ev_overcurrent (ev_overcurrent),
    .gpwr_set       (gpwr_set),
    .pwr_mode       (pwr_mode),
    .pwr_mask       (pwr_mask)
);

// File: tb/tb_usb_rh_port_reg.sv
module tb_usb_rh_port_reg;

    localparam logic [31:0] CCS  = 32'h1;
    localparam logic [31:0] PES  = 32'h2;
    localparam logic [31:0] PSS  = 32'h4;
    localparam logic [31:0] SUSX = 32'h8;
    localparam logic [31:0] PRS  = 32'h10;
    localparam logic [31:0] PPS  = 32'h100;
    localparam logic [31:0] LSDA = 32'h200;
    localparam logic [31:0] CSC  = 32'h1_0000;
    localparam logic [31:0] PESC = 32'h2_0000;
    localparam logic [31:0] ALL  = 32'hFFFF_FFFF;

    localparam int E_CON  = 0;
    localparam int E_DIS  = 1;
    localparam int E_LS   = 2;
    localparam int E_RDN  = 3;
    localparam int E_HWD  = 4;
    localparam int E_OC   = 5;
    localparam int E_GSET = 6;
    localparam int E_GCLR = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ev_connect = 1'b0, ev_disconnect = 1'b0, dev_lowspeed = 1'b0;
    logic        ev_reset_done = 1'b0, ev_hw_disable = 1'b0, ev_overcurrent = 1'b0;
    logic        gpwr_set = 1'b0, gpwr_clr = 1'b0, pwr_mode = 1'b0, pwr_mask = 1'b0;
    logic [31:0] rd_a, rd_b;

    int tests = 0;
    int fails = 0;
    bit timeout = 1'b0;

    string       q_tag[$];
    int          q_sel[$];
    logic [31:0] q_mask[$];
    logic [31:0] q_exp[$];

    always #10 clk = ~clk;

    usb_rh_port_reg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
        .ev_connect(ev_connect), .ev_disconnect(ev_disconnect),
        .dev_lowspeed(dev_lowspeed), .ev_reset_done(ev_reset_done),
        .ev_hw_disable(ev_hw_disable), .ev_overcurrent(ev_overcurrent),
        .gpwr_set(gpwr_set), .gpwr_clr(gpwr_clr), .pwr_mode(pwr_mode), .pwr_mask(pwr_mask)
    );

    usb_rh_port_reg #(.POWER_SWITCHING(1'b0), .DEV_REMOVABLE(1'b1)) dut_fixed (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
        .ev_connect(ev_connect), .ev_disconnect(ev_disconnect),
        .dev_lowspeed(dev_lowspeed), .ev_reset_done(ev_reset_done),
        .ev_hw_disable(ev_hw_disable), .ev_overcurrent(ev_overcurrent),
        .gpwr_set(gpwr_set), .gpwr_clr(gpwr_clr), .pwr_mode(pwr_mode), .pwr_mask(pwr_mask)
    );

    // Monitor: pops every pending expectation and compares it with the outputs.
    always @(negedge clk) begin
        while (q_tag.size() > 0) begin
            string       tag;
            int          sel;
            logic [31:0] m, e, got;
            tag = q_tag.pop_front();
            sel = q_sel.pop_front();
            m   = q_mask.pop_front();
            e   = q_exp.pop_front();
            got = (sel == 0) ? rd_a : rd_b;
            tests++;
            if ((got & m) !== (e & m)) begin
                fails++;
                $display("FAIL %s: got %h expected %h (mask %h)", tag, got & m, e & m, m);
            end
        end
    end

    task automatic expect_a(input string tag, input logic [31:0] e);
        q_tag.push_back(tag); q_sel.push_back(0); q_mask.push_back(ALL); q_exp.push_back(e);
    endtask

    task automatic expect_b(input string tag, input logic [31:0] m, input logic [31:0] e);
        q_tag.push_back(tag); q_sel.push_back(1); q_mask.push_back(m); q_exp.push_back(e);
    endtask

    // Driver: applies one cycle of stimulus; returns just after the edge that used it.
    task automatic op(input logic w, input logic [31:0] d, input logic [7:0] ev);
        @(posedge clk); #2;
        wr_en = w; wr_data = d;
        ev_connect = ev[E_CON]; ev_disconnect = ev[E_DIS]; dev_lowspeed = ev[E_LS];
        ev_reset_done = ev[E_RDN]; ev_hw_disable = ev[E_HWD]; ev_overcurrent = ev[E_OC];
        gpwr_set = ev[E_GSET]; gpwr_clr = ev[E_GCLR];
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
        ev_connect = 1'b0; ev_disconnect = 1'b0; dev_lowspeed = 1'b0;
        ev_reset_done = 1'b0; ev_hw_disable = 1'b0; ev_overcurrent = 1'b0;
        gpwr_set = 1'b0; gpwr_clr = 1'b0;
    endtask

    task automatic run_seq();
        repeat (3) @(posedge clk);
        #2;
        expect_a("R1 reset state", 32'h0);
        expect_b("R11 reset state fixed power", ALL, PPS);
        rst = 1'b0;
        @(posedge clk); #2;
        expect_a("R1 first cycle after reset", 32'h0);
        expect_b("R12 boot connect change", ALL, PPS | CSC);

        op(1'b1, PPS, 8'h0);
        expect_a("R8 port power write ignored in global mode", 32'h0);
        op(1'b0, 0, 8'(1 << E_GSET));
        expect_a("R8 global power on", PPS);

        op(1'b0, 0, 8'((1 << E_CON) | (1 << E_LS)));
        expect_a("R4 R6 low-speed attach", PPS | CCS | CSC | LSDA);
        op(1'b1, 32'h0, 8'h0);
        expect_a("R3 write 0 keeps flag", PPS | CCS | CSC | LSDA);
        op(1'b1, CSC, 8'h0);
        expect_a("R3 clear connect change", PPS | CCS | LSDA);
        expect_b("R12 boot flag cleared", CSC, 32'h0);

        op(1'b1, PES, 8'h0);
        expect_a("R13 set enable", PPS | CCS | LSDA | PES);
        op(1'b1, CCS, 8'h0);
        expect_a("R2 driver disable sets no flag", PPS | CCS | LSDA);
        op(1'b1, PES, 8'h0);
        op(1'b0, 0, 8'(1 << E_HWD));
        expect_a("R2 hardware disable sets flag", PPS | CCS | LSDA | PESC);
        op(1'b1, PES, 8'h0);
        op(1'b1, PESC, 8'(1 << E_HWD));
        expect_a("R3 set wins over clear", PPS | CCS | LSDA | PESC);
        op(1'b1, PESC, 8'h0);
        expect_a("R3 clear enable change", PPS | CCS | LSDA);

        op(1'b1, PSS, 8'h0);
        expect_a("R13 suspend", PPS | CCS | LSDA | PSS);
        op(1'b1, SUSX, 8'h0);
        expect_a("R13 resume", PPS | CCS | LSDA);
        op(1'b1, PRS, 8'h0);
        expect_a("R13 reset start", PPS | CCS | LSDA | PRS);
        op(1'b0, 0, 8'(1 << E_RDN));
        expect_a("R13 reset done enables", PPS | CCS | LSDA | PES);

        op(1'b0, 0, 8'(1 << E_DIS));
        expect_a("R4 R2 R6 detach", PPS | PESC | CSC);
        expect_b("R12 detach sets no change flag", CSC | CCS, 32'h0);

        op(1'b1, CSC | PESC, 8'h0);
        expect_a("R3 clear both flags", PPS);
        op(1'b1, PRS | PES | PSS, 8'h0);
        expect_a("R5 commands on empty port", PPS | CSC);
        op(1'b1, CSC, 8'h0);

        op(1'b0, 0, 8'(1 << E_CON));
        expect_a("R6 full-speed attach", PPS | CCS | CSC);
        op(1'b1, CSC, 8'h0);
        op(1'b1, PES | PSS, 8'h0);
        expect_a("R13 enable and suspend", PPS | CCS | PES | PSS);

        op(1'b0, 0, 8'(1 << E_GCLR));
        expect_a("R10 power off clears link state", 32'h0);
        expect_b("R11 global off ignored", PPS, PPS);
        op(1'b0, 0, 8'(1 << E_CON));
        expect_a("R10 attach ignored while off", 32'h0);

        pwr_mode = 1'b1; pwr_mask = 1'b1;
        op(1'b0, 0, 8'(1 << E_GSET));
        expect_a("R9 global on ignored when masked", 32'h0);
        op(1'b1, PPS, 8'h0);
        expect_a("R9 port power on", PPS);
        op(1'b1, LSDA, 8'h0);
        expect_a("R9 port power off", 32'h0);

        pwr_mask = 1'b0;
        op(1'b1, PPS, 8'h0);
        expect_a("R9 port write ignored when unmasked", 32'h0);
        op(1'b0, 0, 8'(1 << E_GSET));
        expect_a("R9 global on when unmasked", PPS);

        op(1'b0, 0, 8'(1 << E_OC));
        expect_a("R7 overcurrent cuts power", 32'h0);
        expect_b("R11 overcurrent ignored", PPS, PPS);

        @(negedge clk); #1;
    endtask

    initial begin
        fork
            run_seq();
            begin
                repeat (20000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule